// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Expander

A serial bit stream is loaded into a chain of shift slices on one strobe. On a second, independent strobe it is copied as a whole into a storage stage, which drives the parallel outputs. The strobes are `shift_i` and `latch_i`, and both are sampled on `clk_i`. Because the storage stage only changes when it is told to, the outputs never show partially shifted data. A whole multi-slice frame can be shifted in and then presented on one edge.

Each slice is `WIDTH` bits wide, and `N_DEV` slices are chained internally. The top bit of one slice feeds bit 0 of the next. The top bit of the last slice leaves on `ser_o`, so further expanders can be cascaded externally. An active-low clear empties the shift stage at once, without a clock, and leaves the storage stage alone.

An active-low output enable controls the parallel outputs. On-chip, the outputs are a data bus plus an active-high per-bit enable. Tri-state pad drivers sit at the top level only.

Top module: `latched_sipo_expander`

## Requirements
- R1: While `rst_ni` is low, the shift stage, the storage stage, `q_o` and `ser_o` are all zero.
- R2: On a clock edge with `shift_i` high, global shift bit 0 takes `ser_i` and every other bit k takes bit k-1. With `shift_i` low the shift stage holds its value.
- R3: On a clock edge with `latch_i` high, `q_o` takes the whole shift stage. Without `latch_i`, `q_o` keeps its value even while shifting continues.
- R4: When `shift_i` and `latch_i` are high on the same edge, `q_o` takes the shift-stage value from before that edge's shift.
- R5: When `clr_ni` goes low, the shift stage goes to zero without waiting for a clock, so `ser_o` reads 0. `q_o` is unchanged until the next latch, which then presents zeros.
- R6: `ser_o` equals global shift bit `N_DEV*WIDTH-1`. A bit entered on `ser_i` appears on `ser_o` after exactly `N_DEV*WIDTH` shifts.
- R7: With `oe_ni` high, every bit of `q_en_o` is 0 and `q_pad_o` floats. `q_o` keeps the stored data, and `ser_o` still follows the shift stage.
- R8: With `oe_ni` low, every bit of `q_en_o` is 1 and `q_pad_o` equals `q_o`.
- R9: After `N_DEV*WIDTH` shifts, one latch edge moves all `N_DEV*WIDTH` outputs from the old frame to the new frame in the same cycle. Device d occupies `q_o[d*WIDTH +: WIDTH]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock on which both strobes are sampled |
| rst_ni | input | 1 | Active-low asynchronous reset of both stages |
| clr_ni | input | 1 | Active-low asynchronous clear of the shift stage only |
| ser_i | input | 1 | Serial data into global bit 0 |
| shift_i | input | 1 | Shift strobe |
| latch_i | input | 1 | Storage-load strobe |
| oe_ni | input | 1 | Active-low parallel output enable |
| ser_o | output | 1 | Cascade output, top shift bit |
| q_o | output | N_DEV*WIDTH | Storage-stage data |
| q_en_o | output | N_DEV*WIDTH | Per-bit output-enable flag |
| q_pad_o | output | N_DEV*WIDTH | Tri-stated parallel outputs |

## Verification
Several shift patterns are used, and each separates a different kind of fault.
- A single marching one shows the shift direction and the exact number of shifts to `ser_o`.
- An alternating frame and an irregular 16-bit frame expose swapped bits or swapped devices on `q_o`.
- Shifting without latching separates the storage stage from the shift stage.
- Shifting and latching on the same edge shows whether the pre-shift or the post-shift value is captured.
- The clear is applied mid-cycle with the strobes idle, which proves it needs no clock and does not reach the stored data.
- Output-enable toggling is paired with a frame already on `q_o`, so lost data and a gated cascade output both show.

// File: rtl/xp_pkg.sv
package xp_pkg;
  parameter int unsigned XP_WIDTH = 8;
  parameter int unsigned XP_N_DEV = 2;
endpackage

// File: rtl/xp_shift_stage.sv
module xp_shift_stage #(
  parameter int unsigned WIDTH = xp_pkg::XP_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             ser_i,
  input  logic             shift_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni || !clr_ni) q_o <= '0;
    else if (shift_i)       q_o <= {q_o[WIDTH-2:0], ser_i};
  end
endmodule

// File: rtl/xp_store_stage.sv
module xp_store_stage #(
  parameter int unsigned WIDTH = xp_pkg::XP_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // clr_ni deliberately not connected: storage survives a shift clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (latch_i) q_o <= d_i;
  end
endmodule

// File: rtl/latched_sipo_expander.sv
module latched_sipo_expander #(
  parameter int unsigned WIDTH = xp_pkg::XP_WIDTH,
  parameter int unsigned N_DEV = xp_pkg::XP_N_DEV
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_ni,
  input  logic                   ser_i,
  input  logic                   shift_i,
  input  logic                   latch_i,
  input  logic                   oe_ni,
  output logic                   ser_o,
  output logic [N_DEV*WIDTH-1:0] q_o,
  output logic [N_DEV*WIDTH-1:0] q_en_o,
  output logic [N_DEV*WIDTH-1:0] q_pad_o
);
  localparam int unsigned N_BITS = N_DEV * WIDTH;

  logic [N_DEV-1:0][WIDTH-1:0] sh_q;
  logic [N_DEV-1:0][WIDTH-1:0] st_q;
  logic [N_DEV-1:0]            chain_in;
  logic [N_BITS-1:0]           shift_q;

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    if (d == 0) begin : g_head
      assign chain_in[d] = ser_i;
    end else begin : g_link
      assign chain_in[d] = sh_q[d-1][WIDTH-1];
    end

    xp_shift_stage #(.WIDTH(WIDTH)) u_sh (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_ni  (clr_ni),
      .ser_i   (chain_in[d]),
      .shift_i (shift_i),
      .q_o     (sh_q[d])
    );

    xp_store_stage #(.WIDTH(WIDTH)) u_st (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .latch_i (latch_i),
      .d_i     (sh_q[d]),
      .q_o     (st_q[d])
    );
  end

  assign shift_q = sh_q;
  assign ser_o   = sh_q[N_DEV-1][WIDTH-1];
  assign q_o     = st_q;
  assign q_en_o  = {N_BITS{~oe_ni}};

  // pad drivers: the only tri-state logic in the block
  for (genvar b = 0; b < N_BITS; b++) begin : g_pad
    assign q_pad_o[b] = q_en_o[b] ? q_o[b] : 1'bz;
  end
endmodule

// File: rtl/latched_sipo_expander_chk.sv
module latched_sipo_expander_chk #(
  parameter int unsigned N_BITS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_ni,
  input logic              ser_i,
  input logic              shift_i,
  input logic              latch_i,
  input logic              oe_ni,
  input logic              ser_o,
  input logic [N_BITS-1:0] q_o,
  input logic [N_BITS-1:0] q_en_o,
  input logic [N_BITS-1:0] shift_q
);
  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && clr_ni) |=> (!clr_ni || shift_q == {$past(shift_q[N_BITS-2:0]), $past(ser_i)}));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && clr_ni) |=> (!clr_ni || $stable(shift_q)));

  p_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> q_o == $past(shift_q));

  p_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(q_o));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (shift_q == '0 && !ser_o));

  p_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> q_en_o == '0);

  p_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> $countones(q_en_o) == N_BITS);
endmodule

bind latched_sipo_expander latched_sipo_expander_chk #(.N_BITS(N_BITS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_ni  (clr_ni),
  .ser_i   (ser_i),
  .shift_i (shift_i),
  .latch_i (latch_i),
  .oe_ni   (oe_ni),
  .ser_o   (ser_o),
  .q_o     (q_o),
  .q_en_o  (q_en_o),
  .shift_q (shift_q)
);

// File: tb/sim_latched_sipo_expander.sv
`timescale 1ns/1ps
module sim_latched_sipo_expander;
  localparam int W = 8;
  localparam int N = 2;
  localparam int NB = N * W;

  logic clk_i = 1'b0, rst_ni = 1'b0, clr_ni = 1'b1;
  logic ser_i = 1'b0, shift_i = 1'b0, latch_i = 1'b0, oe_ni = 1'b0;
  logic ser_o;
  logic [NB-1:0] q_o, q_en_o, q_pad_o;

  logic [NB-1:0] exp_sr = '0, exp_st = '0;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  latched_sipo_expander #(.WIDTH(W), .N_DEV(N)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .ser_i(ser_i),
    .shift_i(shift_i), .latch_i(latch_i), .oe_ni(oe_ni), .ser_o(ser_o),
    .q_o(q_o), .q_en_o(q_en_o), .q_pad_o(q_pad_o)
  );

  task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, model the edge, come back to the next negedge
  task automatic cyc(input logic s, input logic sh, input logic la);
    ser_i = s; shift_i = sh; latch_i = la;
    @(posedge clk_i);
    if (la) exp_st = exp_sr;
    if (sh) exp_sr = {exp_sr[NB-2:0], s};
    @(negedge clk_i);
    shift_i = 1'b0; latch_i = 1'b0;
  endtask

  task automatic load_frame(input logic [NB-1:0] f);
    for (int i = NB - 1; i >= 0; i--) cyc(f[i], 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 q_o in reset", q_o, '0);
    chk("R1 ser_o in reset", {{(NB-1){1'b0}}, ser_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
    chk("R1 q_o after reset", q_o, '0);
  endtask

  task automatic t_shift_hold();
    cyc(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < NB - 2; i++) cyc(1'b0, 1'b1, 1'b0);
    chk("R6 ser_o before last shift", {{(NB-1){1'b0}}, ser_o}, '0);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R6 ser_o after N*W shifts", {{(NB-1){1'b0}}, ser_o}, 1);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R2 hold keeps ser_o", {{(NB-1){1'b0}}, ser_o}, 1);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R2 marching one stays at top", q_o, exp_st);
    chk("R2 top bit set", q_o, 16'h8000);
  endtask

  task automatic t_latch_only();
    load_frame(16'h5555);
    chk("R3 q_o unchanged by shifting", q_o, 16'h8000);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R3 latch loads whole stage", q_o, 16'h5555);
  endtask

  task automatic t_simul();
    cyc(1'b1, 1'b1, 1'b1);
    chk("R4 pre-shift value captured", q_o, 16'h5555);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R4 shifted value on next latch", q_o, 16'hAAAB);
  endtask

  task automatic t_clear();
    load_frame(16'hFFFF);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R5 setup frame", q_o, 16'hFFFF);
    #3 clr_ni = 1'b0; #2;
    chk("R5 ser_o cleared without clock", {{(NB-1){1'b0}}, ser_o}, '0);
    chk("R5 q_o kept during clear", q_o, 16'hFFFF);
    @(negedge clk_i); clr_ni = 1'b1; exp_sr = '0;
    chk("R5 q_o kept after clear", q_o, 16'hFFFF);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R5 latch after clear gives zeros", q_o, '0);
  endtask

  task automatic t_oe_frame();
    load_frame(16'hA5C3);
    chk("R9 old frame still shown", q_o, '0);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R9 new frame in one latch", q_o, 16'hA5C3);
    chk("R8 enable all on", q_en_o, '1);
    chk("R8 pads follow q_o", q_pad_o, 16'hA5C3);
    oe_ni = 1'b1; #2;
    chk("R7 enable all off", q_en_o, '0);
    chk("R7 data held while disabled", q_o, 16'hA5C3);
    chk("R7 ser_o still driven", {{(NB-1){1'b0}}, ser_o}, {{(NB-1){1'b0}}, exp_sr[NB-1]});
    @(negedge clk_i);
    oe_ni = 1'b0; #2;
    chk("R8 pads return", q_pad_o, 16'hA5C3);
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #5;
    t_reset();
    t_shift_hold();
    t_latch_only();
    t_simul();
    t_clear();
    t_oe_frame();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule